// File: doc/BRIEF.md
# Parallel Port Debouncer with Edge Flags

This block cleans up a multi-lane input port (eight lanes by default). All lanes are sampled together whenever the sample-enable input is high. Each lane shifts its raw bit into a short history register. The lane's debounced bit is forced high once every stored sample is 1 and forced low once every stored sample is 0. Any mixed history leaves the debounced bit as it was, so a short glitch does not change the output.

Alongside the filtered port, the block gives two flag vectors. A rise flag pulses when a lane's debounced bit goes from 0 to 1, and a fall flag pulses when it goes from 1 to 0. Each flag compares the new debounced value with the value held from the previous sample. The surrounding logic supplies an already synchronised input and a sample tick, and can read debounced levels and transition events for the whole port in one cycle.

Top module: `port_debounce`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it is released, `deb_o`, `rose_o` and `fell_o` are all 0. Reset also clears every history bit to 0, so after reset a lane needs three enabled samples of 1 before its debounced bit sets.
- R2: When a lane has seen 1 on three enabled samples in a row, its `deb_o` bit is 1 in the cycle that follows the clock edge of the third sample.
- R3: When a lane has seen 0 on three enabled samples in a row, its `deb_o` bit is 0 in the cycle that follows the clock edge of the third sample.
- R4: When a lane's last three enabled samples are mixed, its `deb_o` bit keeps its previous value.
- R5: All lanes update on the same enabled sample, and each lane depends only on its own input bit. Bit i of `raw_i` drives bit i of each output vector.
- R6: In the cycle after an enabled sample that moves a lane's debounced bit from 0 to 1, that lane's `rose_o` bit is 1. At all other times it is 0, so with the enable held high the pulse lasts exactly one cycle.
- R7: In the cycle after an enabled sample that moves a lane's debounced bit from 1 to 0, that lane's `fell_o` bit is 1. At all other times it is 0.
- R8: A cycle with `sample_en` low changes neither the history nor `deb_o`, and it leaves `rose_o` and `fell_o` at 0 in the following cycle.
- R9: No flag is raised by the first enabled sample after reset, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Sample tick; when high, every lane takes its raw bit on this edge |
| raw_i | input | LANES (8) | Raw port value, already synchronised to `clk` |
| deb_o | output | LANES (8) | Debounced port value |
| rose_o | output | LANES (8) | Per-lane pulse for a debounced 0-to-1 transition |
| fell_o | output | LANES (8) | Per-lane pulse for a debounced 1-to-0 transition |

## Verification
Assertions check, on every cycle, the rules that hold at any instant. A debounced bit never moves while the enable is low. A debounced bit only rises over an all-ones history and only falls over an all-zeros history. A rise flag never coincides with a fall flag on the same lane, and each flag matches the change in the debounced bit it reports. Whether the filter waits for exactly three samples, treats a reset history as zeros, and keeps lanes apart under opposite patterns can only be shown by the bench's directed scenarios. Those scenarios include a bouncing fourteen-sample sequence played on alternating lanes.

// File: rtl/deb_pkg.sv
package deb_pkg;

   // Action a lane takes on its hold register for one sample.
   typedef enum logic [1:0] {
      ACT_KEEP  = 2'd0,
      ACT_FORCE = 2'd1,
      ACT_DROP  = 2'd2
   } deb_act_e;

   // Choose the action from two summaries of the updated history.
   function automatic deb_act_e pick_action(input logic agree_hi, input logic agree_lo);
      deb_act_e act;
      if (agree_hi)      act = ACT_FORCE;
      else if (agree_lo) act = ACT_DROP;
      else               act = ACT_KEEP;
      return act;
   endfunction

endpackage

// File: rtl/deb_lane.sv
module deb_lane #(
   parameter int DEPTH = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic raw_bit,
   output logic lvl_q,
   output logic lvl_next
);
   import deb_pkg::*;

   logic [DEPTH-1:0] hist_q;
   logic [DEPTH-1:0] hist_d;
   deb_act_e         act;
   logic             lvl_d;

   // Newest sample enters at bit 0.
   assign hist_d = {hist_q[DEPTH-2:0], raw_bit};
   assign act    = pick_action(&hist_d, ~|hist_d);

   always_comb begin
      unique case (act)
         ACT_FORCE: lvl_d = 1'b1;
         ACT_DROP:  lvl_d = 1'b0;
         default:   lvl_d = lvl_q;
      endcase
   end

   // Value the hold register takes on this edge (held when not sampling).
   assign lvl_next = en ? lvl_d : lvl_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hist_q <= '0;
         lvl_q  <= 1'b0;
      end else if (en) begin
         hist_q <= hist_d;
         lvl_q  <= lvl_d;
      end
   end

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(lvl_q));                                       // R8
   AST_SET_NEEDS_ONES: assert property (@(posedge clk) disable iff (rst)
      $rose(lvl_q) |-> (&hist_q));                                   // R2
   AST_CLR_NEEDS_ZEROS: assert property (@(posedge clk) disable iff (rst)
      $fell(lvl_q) |-> (~|hist_q));                                  // R3

endmodule

// File: rtl/deb_edge.sv
module deb_edge #(
   parameter int LANES = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [LANES-1:0] cur_lvl,
   input  logic [LANES-1:0] nxt_lvl,
   output logic [LANES-1:0] rose_q,
   output logic [LANES-1:0] fell_q
);

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         rose_q <= '0;
         fell_q <= '0;
      end else begin
         rose_q <= nxt_lvl & ~cur_lvl;
         fell_q <= cur_lvl & ~nxt_lvl;
      end
   end

   AST_FLAGS_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !en |=> (rose_q == '0 && fell_q == '0));                       // R8
   AST_NO_DUAL_FLAG: assert property (@(posedge clk) disable iff (rst)
      (rose_q & fell_q) == '0);                                      // R6
   AST_ROSE_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (rst)
      (|rose_q) |-> ((rose_q & ~cur_lvl) == '0));                    // R6
   AST_FELL_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (rst)
      (|fell_q) |-> ((fell_q & cur_lvl) == '0));                     // R7

endmodule

// File: rtl/port_debounce.sv
module port_debounce #(
   parameter int LANES = 8,
   parameter int DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sample_en,
   input  logic [LANES-1:0] raw_i,
   output logic [LANES-1:0] deb_o,
   output logic [LANES-1:0] rose_o,
   output logic [LANES-1:0] fell_o
);

   localparam int LAST_LANE = LANES - 1;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("port_debounce: LANES must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("port_debounce: DEPTH must be at least 2");
      end
   endgenerate

   logic [LAST_LANE:0] lvl_q;
   logic [LAST_LANE:0] lvl_next;

   // One filter per lane, all clocked by the same sample tick.
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         deb_lane #(.DEPTH(DEPTH)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .en       (sample_en),
            .raw_bit  (raw_i[i]),
            .lvl_q    (lvl_q[i]),
            .lvl_next (lvl_next[i])
         );
      end
   endgenerate

   deb_edge #(.LANES(LANES)) u_edge (
      .clk     (clk),
      .rst     (rst),
      .en      (sample_en),
      .cur_lvl (lvl_q),
      .nxt_lvl (lvl_next),
      .rose_q  (rose_o),
      .fell_q  (fell_o)
   );

   assign deb_o = lvl_q;

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (deb_o == '0 && rose_o == '0 && fell_o == '0));        // R1

endmodule

// File: tb/port_debounce_test.sv
module port_debounce_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sample_en = 1'b0;
   logic [7:0] raw_i = 8'h00;
   logic [7:0] deb_o, rose_o, fell_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   port_debounce #(.LANES(8), .DEPTH(3)) uut (
      .clk(clk), .rst(rst), .sample_en(sample_en), .raw_i(raw_i),
      .deb_o(deb_o), .rose_o(rose_o), .fell_o(fell_o)
   );

   task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic step(input logic e, input logic [7:0] r);
      @(negedge clk);
      sample_en = e;
      raw_i     = r;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; sample_en = 1'b0; raw_i = 8'h00;
      repeat (2) @(posedge clk);
      #1;
      chk("R1", "deb in reset", deb_o, 8'h00);
      chk("R1", "rose in reset", rose_o, 8'h00);
      chk("R1", "fell in reset", fell_o, 8'h00);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #1;
      chk("R1", "deb after release", deb_o, 8'h00);
   endtask

   // Three ones after reset set every lane; flag lasts one sample.
   task automatic t_rise_from_reset();
      do_reset();
      step(1'b1, 8'hFF);
      chk("R9", "rose first sample", rose_o, 8'h00);
      chk("R9", "fell first sample", fell_o, 8'h00);
      chk("R1", "deb after one sample", deb_o, 8'h00);
      step(1'b1, 8'hFF);
      chk("R1", "deb after two samples", deb_o, 8'h00);
      step(1'b1, 8'hFF);
      chk("R2", "deb after three ones", deb_o, 8'hFF);
      chk("R6", "rose on set", rose_o, 8'hFF);
      chk("R7", "fell on set", fell_o, 8'h00);
      step(1'b1, 8'hFF);
      chk("R6", "rose next sample", rose_o, 8'h00);
      chk("R2", "deb stays set", deb_o, 8'hFF);
   endtask

   // Enable low: nothing shifts, flags stay low; then three zeros clear.
   task automatic t_enable_hold();
      for (int k = 0; k < 5; k++) begin
         step(1'b0, 8'h00);
         chk("R8", "deb while idle", deb_o, 8'hFF);
         chk("R8", "rose while idle", rose_o, 8'h00);
         chk("R8", "fell while idle", fell_o, 8'h00);
      end
      step(1'b1, 8'h00);
      chk("R8", "deb one zero after idle", deb_o, 8'hFF);
      step(1'b1, 8'h00);
      chk("R4", "deb two zeros", deb_o, 8'hFF);
      step(1'b1, 8'h00);
      chk("R3", "deb after three zeros", deb_o, 8'h00);
      chk("R7", "fell on clear", fell_o, 8'hFF);
      chk("R6", "rose on clear", rose_o, 8'h00);
      step(1'b0, 8'hFF);
      chk("R8", "fell dropped with enable low", fell_o, 8'h00);
      chk("R8", "deb held with enable low", deb_o, 8'h00);
   endtask

   // Bouncing sequence on even lanes, its inverse on odd lanes.
   task automatic t_bounce_lanes();
      logic [13:0] seq  = 14'b10010100010111;
      logic [13:0] ev_e = 14'b00000000000001;
      logic [13:0] od_e = 14'b00000000111110;
      logic [7:0]  prev = 8'h00;
      do_reset();
      for (int k = 13; k >= 0; k--) begin
         logic [7:0] exp_d;
         exp_d = (ev_e[k] ? 8'h55 : 8'h00) | (od_e[k] ? 8'hAA : 8'h00);
         step(1'b1, seq[k] ? 8'h55 : 8'hAA);
         chk("R4", "deb during bounce", deb_o, exp_d);
         chk("R5", "lanes rose", rose_o, exp_d & ~prev);
         chk("R7", "lanes fell", fell_o, prev & ~exp_d);
         prev = exp_d;
      end
   endtask

   // Mixed lane pattern: low nibble set, high nibble stays clear.
   task automatic t_split_port();
      do_reset();
      step(1'b1, 8'h0F);
      step(1'b1, 8'h0F);
      step(1'b1, 8'h0F);
      chk("R5", "split deb", deb_o, 8'h0F);
      chk("R6", "split rose", rose_o, 8'h0F);
      step(1'b1, 8'hF0);
      step(1'b1, 8'h0F);
      step(1'b1, 8'hF0);
      chk("R4", "split mixed hold", deb_o, 8'h0F);
      chk("R6", "split no rose", rose_o, 8'h00);
      chk("R7", "split no fell", fell_o, 8'h00);
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_rise_from_reset();
      t_enable_hold();
      t_bounce_lanes();
      t_split_port();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule